// File: doc/BRIEF.md
# Region Start-Address Control Register with Privilege Access Checks

This block holds one 64-bit system control register that describes the start of the currently selected memory region. The register has two parts: an enable flag, and a start address aligned to 64 KiB. Only the address bits from bit 16 upward are stored. The block also contains the combinational check that decides, for each read or write, whether the access completes, is undefined, or traps to privilege level 2 or 3. It also reports the syndrome class that goes with a trap. The caller owns exception entry.

An access is presented on `acc_valid`, with `acc_write` choosing between a read and a write. The outcome and syndrome class follow the same cycle. A write that completes is stored at the next rising clock edge. Read data is combinational and is non-zero only for a completed read. The stored address is masked to the configured physical-address width. The mask is applied on write and again on read.

Top module: `rbr_region_base`

## Requirements
- R1: After reset, a read that completes returns 0: the enable flag is 0 and the address is 0.
- R2: Bit 0 holds the enable flag (1 means enabled). Bits 15:1 and 63:56 always read as 0, whatever was written.
- R3: `pa_mode` selects the width of the stored address field: 0 keeps bits 47:16, 1 keeps bits 51:16, and 2 or 3 keep bits 55:16. Higher bits are cleared on write and also masked on read under the current mode.
- R4: Any access at privilege level 0 is undefined.
- R5: At level 1, the checks run in this order. (a) Level 3 present with `prio_undef` and `top_trap` both set gives undefined. (b) Level 3 present and the state secure (`nonsecure`=0) gives undefined. (c) Level 2 enabled with `hyp_trap` set gives trap to level 2. (d) Level 2 enabled with the fine-grained condition true gives trap to level 2. (e) Level 3 present with `top_trap` set gives undefined if `top_undef` is 1, and trap to level 3 otherwise. (f) Otherwise the access completes. Level 2 is enabled when it is present and either the state is non-secure or level 3 is absent.
- R6: The fine-grained condition holds when `fgt_present` is 1, either level 3 is absent or `fgt_enable` is 1, and the trap bit for the access direction is 1. That bit is `fgt_rd_trap` for a read and `fgt_wr_trap` for a write.
- R7: At level 2, the checks run in this order. Level 3 present with a secure state gives undefined. Then the rule of R5(a) gives undefined. Then the rule of R5(e) applies. Otherwise the access completes. `hyp_trap` and the fine-grained bits have no effect at level 2.
- R8: At level 3, a secure state gives undefined. Otherwise the access completes, and all trap bits are ignored.
- R9: `acc_outcome` is encoded as 0 for complete, 1 for undefined, 2 for trap to level 2 and 3 for trap to level 3. `acc_class` is 0x18 for either trap and 0 otherwise.
- R10: A write that does not complete leaves the register unchanged. A read that does not complete returns 0 on `acc_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_wdata | input | 64 | Write data |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| lvl2_present | input | 1 | Level 2 is implemented |
| lvl3_present | input | 1 | Level 3 is implemented |
| nonsecure | input | 1 | 1 for non-secure state |
| top_trap | input | 1 | Region-access trap bit set by level 3 |
| hyp_trap | input | 1 | Region-access trap bit set by level 2 |
| fgt_present | input | 1 | Fine-grained trapping is implemented |
| fgt_enable | input | 1 | Level-3 enable for fine-grained trapping |
| fgt_rd_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_wr_trap | input | 1 | Fine-grained trap bit for writes |
| prio_undef | input | 1 | Undefined takes priority over the level-3 trap |
| top_undef | input | 1 | A level-3 trap is reported as undefined instead |
| pa_mode | input | 2 | Physical-address width select |
| acc_rdata | output | 64 | Read data |
| acc_outcome | output | 2 | Access outcome code |
| acc_class | output | 6 | Syndrome exception class |

## Verification
The bench targets the orderings where two rules fire together. At level 1, the priority-undefined rule must win over the hypervisor trap, and the hypervisor trap must win over the level-3 trap; a chain in the wrong order would report a trap where undefined is due, or trap to the wrong level. It separates the read and write fine-grained bits and checks the gate on level-3 presence. A design that mixed up the directions would trap writes because of the read bit. A design that ignored the presence gate would let a clear `fgt_enable` suppress the trap even with level 3 absent. Width masking is checked by writing all ones under each mode and by reading back after the mode changes. Blocked writes are followed by a read-back, which exposes a design that stores data on a trapped access.

// File: rtl/rbr_pkg.sv
package rbr_pkg;
    localparam int REG_W     = 64;
    localparam int ADDR_LSB  = 16;
    localparam int MAX_PA    = 56;
    localparam int FIELD_W   = MAX_PA - ADDR_LSB;
    localparam int BASE_PA   = 48;
    localparam int PA_STEP   = 4;
    localparam int TOP_MODE  = 2;
    localparam logic [5:0] TRAP_CLASS = 6'h18;

    typedef enum logic [1:0] {
        OUT_OK      = 2'd0,
        OUT_UNDEF   = 2'd1,
        OUT_TRAP_L2 = 2'd2,
        OUT_TRAP_L3 = 2'd3
    } outcome_e;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic               en;
    } region_t;
endpackage

// File: rtl/rbr_access_check.sv
module rbr_access_check
    import rbr_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] cur_lvl,
    input  logic       lvl2_present,
    input  logic       lvl3_present,
    input  logic       nonsecure,
    input  logic       top_trap,
    input  logic       hyp_trap,
    input  logic       fgt_present,
    input  logic       fgt_enable,
    input  logic       fgt_rd_trap,
    input  logic       fgt_wr_trap,
    input  logic       prio_undef,
    input  logic       top_undef,
    output outcome_e   outcome,
    output logic [5:0] ex_class
);
    logic     l2_on;
    logic     fg_hit;
    logic     secure_l3;
    logic     early_undef;
    logic     late_top;
    outcome_e late_res;

    always_comb begin
        l2_on       = lvl2_present & (nonsecure | ~lvl3_present);
        fg_hit      = fgt_present & (~lvl3_present | fgt_enable)
                      & (is_write ? fgt_wr_trap : fgt_rd_trap);
        secure_l3   = lvl3_present & ~nonsecure;
        early_undef = lvl3_present & prio_undef & top_trap;
        late_top    = lvl3_present & top_trap;
        late_res    = top_undef ? OUT_UNDEF : OUT_TRAP_L3;

        unique case (cur_lvl)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
                if (early_undef)            outcome = OUT_UNDEF;
                else if (secure_l3)         outcome = OUT_UNDEF;
                else if (l2_on && hyp_trap) outcome = OUT_TRAP_L2;
                else if (l2_on && fg_hit)   outcome = OUT_TRAP_L2;
                else if (late_top)          outcome = late_res;
                else                        outcome = OUT_OK;
            end
            2'd2: begin
                if (secure_l3)              outcome = OUT_UNDEF;
                else if (early_undef)       outcome = OUT_UNDEF;
                else if (late_top)          outcome = late_res;
                else                        outcome = OUT_OK;
            end
            default: outcome = nonsecure ? OUT_OK : OUT_UNDEF;
        endcase

        ex_class = (outcome == OUT_TRAP_L2 || outcome == OUT_TRAP_L3)
                   ? TRAP_CLASS : 6'h00;
    end
endmodule

// File: rtl/rbr_pa_mask.sv
module rbr_pa_mask
    import rbr_pkg::*;
(
    input  logic [1:0]         pa_mode,
    output logic [FIELD_W-1:0] field_mask
);
    logic [7:0] pa_width;

    always_comb begin
        if (int'(pa_mode) >= TOP_MODE)
            pa_width = 8'(BASE_PA + PA_STEP * TOP_MODE);
        else
            pa_width = 8'(BASE_PA + PA_STEP * int'(pa_mode));
    end

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        assign field_mask[i] = (8'(i + ADDR_LSB) < pa_width);
    end
endmodule

// File: rtl/rbr_region_base.sv
module rbr_region_base
    import rbr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [63:0] acc_wdata,
    input  logic [1:0]  cur_lvl,
    input  logic        lvl2_present,
    input  logic        lvl3_present,
    input  logic        nonsecure,
    input  logic        top_trap,
    input  logic        hyp_trap,
    input  logic        fgt_present,
    input  logic        fgt_enable,
    input  logic        fgt_rd_trap,
    input  logic        fgt_wr_trap,
    input  logic        prio_undef,
    input  logic        top_undef,
    input  logic [1:0]  pa_mode,
    output logic [63:0] acc_rdata,
    output logic [1:0]  acc_outcome,
    output logic [5:0]  acc_class
);
    outcome_e           outcome;
    logic [FIELD_W-1:0] field_mask;
    region_t            state_d;
    region_t            state_q;
    logic               done_ok;
    logic               unused_wbits;

    assign unused_wbits = ^{acc_wdata[REG_W-1:MAX_PA], acc_wdata[ADDR_LSB-1:1]};

    rbr_access_check u_check (
        .is_write     (acc_write),
        .cur_lvl      (cur_lvl),
        .lvl2_present (lvl2_present),
        .lvl3_present (lvl3_present),
        .nonsecure    (nonsecure),
        .top_trap     (top_trap),
        .hyp_trap     (hyp_trap),
        .fgt_present  (fgt_present),
        .fgt_enable   (fgt_enable),
        .fgt_rd_trap  (fgt_rd_trap),
        .fgt_wr_trap  (fgt_wr_trap),
        .prio_undef   (prio_undef),
        .top_undef    (top_undef),
        .outcome      (outcome),
        .ex_class     (acc_class)
    );

    rbr_pa_mask u_mask (
        .pa_mode    (pa_mode),
        .field_mask (field_mask)
    );

    assign acc_outcome = outcome;
    assign done_ok     = acc_valid && (outcome == OUT_OK);

    always_comb begin
        state_d = state_q;
        if (done_ok && acc_write) begin
            state_d.base = acc_wdata[MAX_PA-1:ADDR_LSB] & field_mask;
            state_d.en   = acc_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        acc_rdata = '0;
        if (done_ok && !acc_write) begin
            acc_rdata[MAX_PA-1:ADDR_LSB] = state_q.base & field_mask;
            acc_rdata[0]                 = state_q.en;
        end
    end
endmodule

// File: rtl/rbr_region_base_chk.sv
module rbr_region_base_chk
    import rbr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  cur_lvl,
    input logic        nonsecure,
    input logic [63:0] acc_rdata,
    input logic [1:0]  acc_outcome,
    input logic [5:0]  acc_class,
    input region_t     state_q
);
    // R4
    lvl0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_lvl == 2'd0) |-> acc_outcome == OUT_UNDEF);

    // R8
    l3_secure_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cur_lvl == 2'd3 && !nonsecure) |-> acc_outcome == OUT_UNDEF);

    // R9
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_outcome[1] |-> acc_class == TRAP_CLASS);

    // R9
    quiet_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_outcome[1] |-> acc_class == 6'h00);

    // R10
    blocked_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_outcome != OUT_OK) |=> $stable(state_q));

    // R10
    blocked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_outcome != OUT_OK) |-> acc_rdata == 64'd0);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[15:1] == 15'd0 && acc_rdata[63:56] == 8'd0);
endmodule

bind rbr_region_base rbr_region_base_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .cur_lvl     (cur_lvl),
    .nonsecure   (nonsecure),
    .acc_rdata   (acc_rdata),
    .acc_outcome (acc_outcome),
    .acc_class   (acc_class),
    .state_q     (state_q)
);

// File: tb/rbr_region_base_test.sv
module rbr_region_base_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [1:0]  cur_lvl = 2'd3;
    logic        lvl2_present = 1'b1, lvl3_present = 1'b1, nonsecure = 1'b1;
    logic        top_trap = 1'b0, hyp_trap = 1'b0;
    logic        fgt_present = 1'b0, fgt_enable = 1'b0;
    logic        fgt_rd_trap = 1'b0, fgt_wr_trap = 1'b0;
    logic        prio_undef = 1'b0, top_undef = 1'b0;
    logic [1:0]  pa_mode = 2'd2;
    logic [63:0] acc_rdata;
    logic [1:0]  acc_outcome;
    logic [5:0]  acc_class;

    int applied = 0;
    int misses  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rbr_region_base uut (.*);

    typedef struct packed {
        logic [1:0] lvl;
        logic h2, h3, ns, tt, ht, fp, fe, fr, fw, pu, tu, wr;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{0,1,1,1,0,0,0,0,0,0,0,0,0,1},
        '{1,1,1,1,0,0,0,0,0,0,0,0,0,0},
        '{1,1,1,1,1,1,0,0,0,0,1,0,0,1},
        '{1,1,1,0,0,1,0,0,0,0,0,0,0,1},
        '{1,1,1,1,1,1,0,0,0,0,0,0,0,2},
        '{1,1,1,1,0,0,1,1,1,0,0,0,0,2},
        '{1,1,1,1,0,0,1,1,1,0,0,0,1,0},
        '{1,1,1,1,0,0,1,0,0,1,0,0,1,0},
        '{1,1,0,1,0,0,1,0,0,1,0,0,1,2},
        '{1,1,1,1,0,0,0,1,1,0,0,0,0,0},
        '{1,0,1,1,0,1,1,1,1,0,0,0,0,0},
        '{1,1,1,1,1,0,0,0,0,0,0,0,0,3},
        '{1,1,1,1,1,0,0,0,0,0,0,1,0,1},
        '{1,1,0,1,1,0,0,0,0,0,0,0,0,0},
        '{2,1,1,0,1,0,0,0,0,0,1,0,0,1},
        '{2,1,1,1,0,1,1,1,1,0,0,0,0,0},
        '{2,1,1,1,1,0,0,0,0,0,0,0,0,3},
        '{2,1,1,1,1,0,0,0,0,0,1,0,0,1},
        '{2,1,1,1,1,0,0,0,0,0,0,1,0,1},
        '{3,1,1,0,0,0,0,0,0,0,0,0,0,1},
        '{3,1,1,1,1,1,0,0,0,0,0,0,0,0},
        '{1,1,1,1,0,0,0,0,0,0,1,0,0,0},
        '{2,1,0,0,0,0,0,0,0,0,0,0,0,0}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        applied++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        cur_lvl = 2'd3; lvl2_present = 1; lvl3_present = 1; nonsecure = 1;
        top_trap = 0; hyp_trap = 0; fgt_present = 0; fgt_enable = 0;
        fgt_rd_trap = 0; fgt_wr_trap = 0; prio_undef = 0; top_undef = 0;
    endtask

    task automatic do_write(input logic [63:0] d);
        @(negedge clk);
        defaults();
        acc_valid = 1; acc_write = 1; acc_wdata = d;
        @(posedge clk);
        #1 acc_valid = 0; acc_write = 0;
    endtask

    task automatic read_chk(input logic [63:0] exp, input string tag);
        @(negedge clk);
        defaults();
        acc_valid = 1; acc_write = 0;
        #1 check(acc_rdata === exp && acc_outcome === 2'd0, tag, acc_rdata, exp);
        acc_valid = 0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            misses++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: reset state reads as zero
        read_chk(64'd0, "R1 reset value");

        // R4 R5 R6 R7 R8 R9: access-check table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cur_lvl = VECS[i].lvl; lvl2_present = VECS[i].h2;
            lvl3_present = VECS[i].h3; nonsecure = VECS[i].ns;
            top_trap = VECS[i].tt; hyp_trap = VECS[i].ht;
            fgt_present = VECS[i].fp; fgt_enable = VECS[i].fe;
            fgt_rd_trap = VECS[i].fr; fgt_wr_trap = VECS[i].fw;
            prio_undef = VECS[i].pu; top_undef = VECS[i].tu;
            acc_write = VECS[i].wr; acc_wdata = '0; acc_valid = 1;
            #1;
            check(acc_outcome === VECS[i].exp,
                  $sformatf("R5/R7 order vector %0d outcome", i),
                  64'(acc_outcome), 64'(VECS[i].exp));
            check(acc_class === (VECS[i].exp[1] ? 6'h18 : 6'h00),
                  $sformatf("R9 class vector %0d", i),
                  64'(acc_class), VECS[i].exp[1] ? 64'h18 : 64'h0);
            if (!VECS[i].wr && VECS[i].exp != 2'd0)
                check(acc_rdata === 64'd0, "R10 blocked read data", acc_rdata, 64'd0);
            @(posedge clk);
            #1 acc_valid = 0; acc_write = 0;
        end

        // R2 R3: widest mode, all ones
        pa_mode = 2'd2;
        do_write('1);
        read_chk(64'h00FF_FFFF_FFFF_0001, "R2 R3 widest mode");
        pa_mode = 2'd3;
        read_chk(64'h00FF_FFFF_FFFF_0001, "R3 mode 3 as widest");
        pa_mode = 2'd1;
        read_chk(64'h000F_FFFF_FFFF_0001, "R3 read mask 52-bit");
        pa_mode = 2'd0;
        read_chk(64'h0000_FFFF_FFFF_0001, "R3 read mask 48-bit");

        // R3: write mask under the narrow mode persists
        do_write('1);
        pa_mode = 2'd2;
        read_chk(64'h0000_FFFF_FFFF_0001, "R3 write mask 48-bit");

        // R2: pattern with enable clear
        do_write(64'h1234_5678_9ABC_DEF0);
        read_chk(64'h0034_5678_9ABC_0000, "R2 pattern enable clear");

        // R10: trapped write leaves register unchanged
        @(negedge clk);
        defaults();
        cur_lvl = 2'd1; top_trap = 1;
        acc_valid = 1; acc_write = 1; acc_wdata = 64'h0000_0000_0001_0001;
        #1 check(acc_outcome === 2'd3, "R10 write trapped to level 3",
                 64'(acc_outcome), 64'd3);
        @(posedge clk);
        #1 acc_valid = 0; acc_write = 0;
        read_chk(64'h0034_5678_9ABC_0000, "R10 blocked write no effect");

        // R4: level-0 write ignored
        @(negedge clk);
        defaults();
        cur_lvl = 2'd0; acc_valid = 1; acc_write = 1; acc_wdata = '1;
        @(posedge clk);
        #1 acc_valid = 0; acc_write = 0;
        read_chk(64'h0034_5678_9ABC_0000, "R4 level-0 write ignored");

        // R10: read at level 0 returns zero even when register is non-zero
        @(negedge clk);
        defaults();
        cur_lvl = 2'd0; acc_valid = 1; acc_write = 0;
        #1 check(acc_rdata === 64'd0, "R10 undefined read zero", acc_rdata, 64'd0);
        acc_valid = 0;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end
endmodule